// File: doc/BRIEF.md
# L2 Cache Miss Predictor

This block sits beside one core's L1 miss handling and guesses, for each new L1 load miss, whether the shared second-level cache will also miss. The guess feeds the priority bit that the network interface places in the request's head flit. Two prediction schemes live side by side, and a mode input picks which one answers. The history scheme keeps a short shift register of recent true L2 outcomes and uses it to index a table of 2-bit saturating counters. The threshold scheme spots miss bursts. It counts known L2 misses over fixed windows of M outcomes and predicts a miss when the last complete window held more misses than a programmable threshold T.

A prediction is asked for with a one-cycle request pulse. One cycle later the block returns the predicted bit and an index tag, which is the history value used for the lookup. The requester keeps the tag with the outstanding miss. When the real L2 outcome arrives, the requester presents the tag and the outcome on the update port. Both schemes learn only from these updates, whatever the mode. The counter that gets trained is the one named by the returned tag, not the one the current history points to.

The threshold scheme has a two-state window machine. In WIN_COLD no window has finished yet. In WIN_WARM a completed-window count is held. The machine has two transitions: COLD_TO_WARM, taken on the update that closes the first window, and WARM_STAY, taken on every later update and on every idle cycle. WIN_COLD is left only by COLD_TO_WARM. Reset is the only way back to it.

Top module: `l2miss_predictor`

## Requirements
- R1: After reset, pred_valid_o, pred_miss_o and pred_tag_o are 0. The history register is 0, every table counter holds 01, and the threshold register holds DEF_THRESH (2).
- R2: pred_valid_o is 1 exactly in the cycle after a cycle with pred_req_i=1. pred_miss_o and pred_tag_o change only in that cycle and hold their values otherwise.
- R3: pred_tag_o is the history register: HIST_BITS (4) true outcomes with the newest in bit 0 and the oldest in the MSB. An update shifts in 1 for an L2 miss and 0 for a hit.
- R4: In history mode (mode_i=0) the block predicts a miss when the counter at the tag holds 2 or more. An update moves its counter up by one on a miss and down by one on a hit, saturating at 0 and 3.
- R5: An update trains the counter at upd_tag_i, whatever value the history register holds.
- R6: In threshold mode (mode_i=1) every WIN_LEN (4) updates form a window. When a window closes, its miss count is latched. The block predicts a miss when the latched count is strictly greater than T, and the count holds until the next window closes.
- R7: In threshold mode, until the first window has closed (WIN_COLD), the block always predicts a hit.
- R8: With thr_load_i=1, T takes thr_value_i at the clock edge. Requests in later cycles use the new T, and a request in the same cycle still uses the old T. If T is WIN_LEN or more, threshold mode never predicts a miss.
- R9: When a request and an update fall in the same cycle, the update is applied first: the tag, the counter read and the window count all include it.
- R10: Both schemes train on every update whatever mode_i says, so switching modes takes effect at once on learned state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 selects the history scheme, 1 selects the threshold scheme |
| thr_load_i | input | 1 | Write strobe for the threshold register |
| thr_value_i | input | CNT_W (3) | New threshold T |
| pred_req_i | input | 1 | Request a prediction for a new L1 miss |
| pred_valid_o | output | 1 | Prediction result valid |
| pred_miss_o | output | 1 | 1 = predicted L2 miss |
| pred_tag_o | output | HIST_BITS (4) | Index tag to return with the outcome |
| upd_valid_i | input | 1 | A true L2 outcome is presented |
| upd_tag_i | input | HIST_BITS (4) | Tag that was returned with the prediction |
| upd_miss_i | input | 1 | True outcome: 1 = L2 miss |

## Verification
Some properties are checked on every cycle:
- the one-cycle request-to-valid timing and the holding of outputs between requests;
- the newest history bit after a same-cycle update;
- the hit-only answer of the threshold scheme before its first window closes;
- the absence of miss predictions whenever T is at least the window length.

Other behaviours need the scoreboard's scenarios, which compare every response against an independent model. These are the counter saturation at both ends, training through a stale tag, the exact window boundary and strict-greater compare, the timing of a threshold write, and the learning that carries over across mode switches.

// File: rtl/l2mp_pkg.sv
package l2mp_pkg;

    typedef enum logic {
        SCHEME_HISTORY   = 1'b0,
        SCHEME_THRESHOLD = 1'b1
    } scheme_e;

    typedef enum logic {
        WIN_COLD = 1'b0,
        WIN_WARM = 1'b1
    } win_state_e;

    localparam logic [1:0] CTR_RESET = 2'b01;

    // One saturating training step of a 2-bit confidence counter
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic miss);
        logic [1:0] res;
        if (miss) res = (cur == 2'b11) ? cur : cur + 2'd1;
        else      res = (cur == 2'b00) ? cur : cur - 2'd1;
        return res;
    endfunction

endpackage

// File: rtl/l2mp_hist_table.sv
module l2mp_hist_table
    import l2mp_pkg::*;
#(
    parameter int HIST_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_valid_i,
    input  logic [HIST_BITS-1:0] upd_tag_i,
    input  logic                 upd_miss_i,
    output logic [HIST_BITS-1:0] look_tag_o,
    output logic                 look_miss_o
);
    localparam int ENTRIES = 1 << HIST_BITS;

    logic [HIST_BITS-1:0] hist_q;
    logic [HIST_BITS-1:0] hist_nxt;
    logic [1:0]           ctr_q [ENTRIES];
    logic [1:0]           upd_cur;
    logic [1:0]           upd_new;
    logic [1:0]           look_ctr;

    // history after any update of this cycle (update goes first)
    always_comb begin
        hist_nxt = hist_q;
        if (upd_valid_i) hist_nxt = {hist_q[HIST_BITS-2:0], upd_miss_i};
    end

    always_comb begin
        upd_cur = ctr_q[upd_tag_i];
        upd_new = ctr_step(upd_cur, upd_miss_i);
    end

    // read-after-write forwarding for a same-cycle update
    always_comb begin
        if (upd_valid_i && (upd_tag_i == hist_nxt)) look_ctr = upd_new;
        else                                        look_ctr = ctr_q[hist_nxt];
    end

    assign look_tag_o  = hist_nxt;
    assign look_miss_o = look_ctr[1];

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_nxt;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n)
                ctr_q[i] <= CTR_RESET;
            else if (upd_valid_i && (upd_tag_i == HIST_BITS'(i)))
                ctr_q[i] <= upd_new;
        end
    end

endmodule

// File: rtl/l2mp_burst_window.sv
module l2mp_burst_window
    import l2mp_pkg::*;
#(
    parameter int WIN_LEN = 4,
    parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid_i,
    input  logic             upd_miss_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             look_miss_o
);
    localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [WIN_W-1:0] LAST_SLOT = WIN_W'(WIN_LEN - 1);

    win_state_e       state_q, state_nxt;
    logic [WIN_W-1:0] slot_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] held_q;
    logic [CNT_W-1:0] run_inc;
    logic             closing;
    logic [CNT_W-1:0] held_nxt;

    assign run_inc  = run_q + CNT_W'(upd_miss_i);
    assign closing  = upd_valid_i && (slot_q == LAST_SLOT);
    assign held_nxt = closing ? run_inc : held_q;

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            WIN_COLD: if (closing) state_nxt = WIN_WARM;   // COLD_TO_WARM
            WIN_WARM: state_nxt = WIN_WARM;                // WARM_STAY
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_COLD;
        else        state_q <= state_nxt;
    end

    // window counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            run_q  <= '0;
            held_q <= '0;
        end else if (upd_valid_i) begin
            if (closing) begin
                slot_q <= '0;
                run_q  <= '0;
                held_q <= run_inc;
            end else begin
                slot_q <= slot_q + WIN_W'(1);
                run_q  <= run_inc;
            end
        end
    end

    // output: prediction as seen after this cycle's update
    always_comb begin
        unique case (state_nxt)
            WIN_COLD: look_miss_o = 1'b0;
            WIN_WARM: look_miss_o = (held_nxt > thr_i);
        endcase
    end

endmodule

// File: rtl/l2miss_predictor.sv
module l2miss_predictor
    import l2mp_pkg::*;
#(
    parameter int HIST_BITS  = 4,
    parameter int WIN_LEN    = 4,
    parameter int CNT_W      = $clog2(WIN_LEN + 1),
    parameter int DEF_THRESH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic                 thr_load_i,
    input  logic [CNT_W-1:0]     thr_value_i,
    input  logic                 pred_req_i,
    output logic                 pred_valid_o,
    output logic                 pred_miss_o,
    output logic [HIST_BITS-1:0] pred_tag_o,
    input  logic                 upd_valid_i,
    input  logic [HIST_BITS-1:0] upd_tag_i,
    input  logic                 upd_miss_i
);
    logic [CNT_W-1:0]     thr_q;
    logic [HIST_BITS-1:0] hist_tag;
    logic                 hist_miss;
    logic                 burst_miss;
    logic                 chosen_miss;

    l2mp_hist_table #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_valid_i (upd_valid_i),
        .upd_tag_i   (upd_tag_i),
        .upd_miss_i  (upd_miss_i),
        .look_tag_o  (hist_tag),
        .look_miss_o (hist_miss)
    );

    l2mp_burst_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_valid_i (upd_valid_i),
        .upd_miss_i  (upd_miss_i),
        .thr_i       (thr_q),
        .look_miss_o (burst_miss)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)          thr_q <= CNT_W'(DEF_THRESH);
        else if (thr_load_i) thr_q <= thr_value_i;
    end

    always_comb begin
        unique case (scheme_e'(mode_i))
            SCHEME_HISTORY:   chosen_miss = hist_miss;
            SCHEME_THRESHOLD: chosen_miss = burst_miss;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid_o <= 1'b0;
            pred_miss_o  <= 1'b0;
            pred_tag_o   <= '0;
        end else begin
            pred_valid_o <= pred_req_i;
            if (pred_req_i) begin
                pred_miss_o <= chosen_miss;
                pred_tag_o  <= hist_tag;
            end
        end
    end

endmodule

// File: rtl/l2mp_checker.sv
module l2mp_checker #(
    parameter int HIST_BITS  = 4,
    parameter int WIN_LEN    = 4,
    parameter int CNT_W      = $clog2(WIN_LEN + 1),
    parameter int DEF_THRESH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mode_i,
    input logic                 thr_load_i,
    input logic [CNT_W-1:0]     thr_value_i,
    input logic                 pred_req_i,
    input logic                 pred_valid_o,
    input logic                 pred_miss_o,
    input logic [HIST_BITS-1:0] pred_tag_o,
    input logic                 upd_valid_i,
    input logic [HIST_BITS-1:0] upd_tag_i,
    input logic                 upd_miss_i
);
    localparam int SEEN_W = $clog2(WIN_LEN + 1);

    logic [CNT_W-1:0]  shadow_thr;
    logic [SEEN_W-1:0] seen_q;
    logic              cold_now;

    always_ff @(posedge clk) begin
        if (!rst_n)          shadow_thr <= CNT_W'(DEF_THRESH);
        else if (thr_load_i) shadow_thr <= thr_value_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else if (upd_valid_i && (int'(seen_q) < WIN_LEN)) seen_q <= seen_q + SEEN_W'(1);
    end

    assign cold_now = (int'(seen_q) + int'(upd_valid_i)) < WIN_LEN;

    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req_i |=> pred_valid_o);

    p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_req_i |=> !pred_valid_o);

    p_hold_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_req_i |=> ($stable(pred_miss_o) && $stable(pred_tag_o)));

    // R3 and R9: newest outcome is already in bit 0 of the returned tag
    p_newest_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_req_i && upd_valid_i) |=> (pred_tag_o[0] == $past(upd_miss_i)));

    p_cold_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_req_i && mode_i && cold_now) |=> !pred_miss_o);

    p_high_thr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_req_i && mode_i && (int'(shadow_thr) >= WIN_LEN)) |=> !pred_miss_o);

endmodule

bind l2miss_predictor l2mp_checker #(
    .HIST_BITS(HIST_BITS), .WIN_LEN(WIN_LEN), .CNT_W(CNT_W), .DEF_THRESH(DEF_THRESH)
) u_l2mp_checker (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .thr_load_i(thr_load_i),
    .thr_value_i(thr_value_i), .pred_req_i(pred_req_i), .pred_valid_o(pred_valid_o),
    .pred_miss_o(pred_miss_o), .pred_tag_o(pred_tag_o), .upd_valid_i(upd_valid_i),
    .upd_tag_i(upd_tag_i), .upd_miss_i(upd_miss_i)
);

// File: tb/test_l2miss_predictor.sv
module test_l2miss_predictor;
    localparam int HB  = 4;
    localparam int WL  = 4;
    localparam int CW  = 3;
    localparam int NE  = 1 << HB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_i = 1'b0;
    logic          thr_load_i = 1'b0;
    logic [CW-1:0] thr_value_i = '0;
    logic          pred_req_i = 1'b0;
    logic          pred_valid_o;
    logic          pred_miss_o;
    logic [HB-1:0] pred_tag_o;
    logic          upd_valid_i = 1'b0;
    logic [HB-1:0] upd_tag_i = '0;
    logic          upd_miss_i = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    l2miss_predictor i_l2miss_predictor (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .thr_load_i(thr_load_i),
        .thr_value_i(thr_value_i), .pred_req_i(pred_req_i), .pred_valid_o(pred_valid_o),
        .pred_miss_o(pred_miss_o), .pred_tag_o(pred_tag_o), .upd_valid_i(upd_valid_i),
        .upd_tag_i(upd_tag_i), .upd_miss_i(upd_miss_i)
    );

    typedef struct {
        logic [HB-1:0] tag;
        logic          miss;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    // reference model state
    int   m_ctr [NE];
    int   m_hist, m_slot, m_run, m_held, m_thr;
    bit   m_warm;

    task automatic model_reset();
        for (int i = 0; i < NE; i++) m_ctr[i] = 1;
        m_hist = 0; m_slot = 0; m_run = 0; m_held = 0; m_thr = 2; m_warm = 0;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, model updated first then prediction formed
    task automatic step(input bit req, input bit mode, input bit uv, input int utag,
                        input bit umiss, input bit ld, input int lval, input string lbl);
        exp_t e;
        @(negedge clk);
        pred_req_i  = req;  mode_i = mode;
        upd_valid_i = uv;   upd_tag_i = HB'(utag); upd_miss_i = umiss;
        thr_load_i  = ld;   thr_value_i = CW'(lval);
        if (uv) begin
            if (umiss) m_ctr[utag] = (m_ctr[utag] == 3) ? 3 : m_ctr[utag] + 1;
            else       m_ctr[utag] = (m_ctr[utag] == 0) ? 0 : m_ctr[utag] - 1;
            m_hist = ((m_hist << 1) | int'(umiss)) & (NE - 1);
            m_run  = m_run + int'(umiss);
            if (m_slot == WL - 1) begin
                m_held = m_run; m_run = 0; m_slot = 0; m_warm = 1;
            end else m_slot++;
        end
        if (req) begin
            e.tag  = HB'(m_hist);
            e.miss = mode ? (m_warm && (m_held > m_thr)) : (m_ctr[m_hist] >= 2);
            e.req  = lbl;
            exp_q.push_back(e);
        end
        if (ld) m_thr = lval;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, mode_i, 0, 0, 0, 0, 0, "R2");
    endtask

    // monitor: compare each result one time unit after the edge that produced it
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && !finished) begin
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    chk(pred_valid_o == 1'b1, "R2", int'(pred_valid_o), 1);
                    chk(pred_tag_o == e.tag, {e.req, " tag"}, int'(pred_tag_o), int'(e.tag));
                    chk(pred_miss_o == e.miss, {e.req, " miss"}, int'(pred_miss_o), int'(e.miss));
                end else begin
                    chk(pred_valid_o == 1'b0, "R2 idle", int'(pred_valid_o), 0);
                end
            end
        end
    end

    initial begin
        #400_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(pred_valid_o == 1'b0, "R1 valid", int'(pred_valid_o), 0);
        chk(pred_miss_o == 1'b0, "R1 miss", int'(pred_miss_o), 0);
        chk(pred_tag_o == '0, "R1 tag", int'(pred_tag_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: fresh table (01) predicts hit at tag 0
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        idle(1);

        // R4: saturate counter 5 upward, then walk it down
        for (int i = 0; i < 5; i++) step(0, 0, 1, 5, 1, 0, 0, "R4");
        // R3: steer history to 0101 = 5 with outcomes 0,1,0,1
        step(0, 0, 1, 0, 0, 0, 0, "R3");
        step(0, 0, 1, 0, 1, 0, 0, "R3");
        step(0, 0, 1, 0, 0, 0, 0, "R3");
        step(0, 0, 1, 0, 1, 0, 0, "R3");
        step(1, 0, 0, 0, 0, 0, 0, "R4 sat-high");
        step(1, 0, 0, 0, 0, 0, 0, "R2 hold");
        step(0, 0, 0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 2; i++) begin
            step(0, 0, 1, 5, 0, 0, 0, "R4");
            // R5: trained tag 5 while history moves elsewhere; re-steer and look
            step(0, 0, 1, 0, 0, 0, 0, "R5"); step(0, 0, 1, 0, 1, 0, 0, "R5");
            step(0, 0, 1, 0, 0, 0, 0, "R5"); step(0, 0, 1, 0, 1, 0, 0, "R5");
            step(1, 0, 0, 0, 0, 0, 0, "R4 step-down");
        end
        for (int i = 0; i < 5; i++) step(0, 0, 1, 5, 0, 0, 0, "R4");
        step(0, 0, 1, 0, 0, 0, 0, "R4"); step(0, 0, 1, 0, 1, 0, 0, "R4");
        step(0, 0, 1, 0, 0, 0, 0, "R4"); step(0, 0, 1, 0, 1, 0, 0, "R4");
        step(1, 0, 0, 0, 0, 0, 0, "R4 sat-low");

        // R9: same-cycle update targeting the new history index
        step(1, 0, 1, 11, 1, 0, 0, "R9 hist");
        step(1, 0, 1, 7, 1, 0, 0, "R9 hist");

        // R7 and R10: threshold mode on a fresh reset
        @(negedge clk); rst_n = 1'b0; model_reset();
        pred_req_i = 0; upd_valid_i = 0; thr_load_i = 0;
        exp_q.delete();
        @(negedge clk); rst_n = 1'b1;
        step(1, 1, 1, 0, 1, 0, 0, "R7 cold");
        step(1, 1, 1, 0, 1, 0, 0, "R7 cold");
        step(1, 1, 1, 0, 1, 0, 0, "R7 cold");
        // R9 and R6: fourth outcome closes window in same cycle: 3 misses > 2
        step(1, 1, 1, 0, 0, 0, 0, "R9 window");
        step(1, 1, 0, 0, 0, 0, 0, "R6 held");
        // R8: load T=3 with a request in the same cycle (old T still used)
        step(1, 1, 0, 0, 0, 1, 3, "R8 same-cycle");
        step(1, 1, 0, 0, 0, 0, 0, "R8 new");
        // R6: window of 4 misses > 3, held across idle
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 1, 0, 0, "R6");
        step(1, 1, 0, 0, 0, 0, 0, "R6 burst");
        step(1, 0, 0, 0, 0, 0, 0, "R10 hist after thr");
        // R8: T=4 (= window length) never predicts miss
        step(0, 1, 0, 0, 0, 1, 4, "R8");
        step(1, 1, 0, 0, 0, 0, 0, "R8 high");
        // R6: exactly T misses is not a miss
        step(0, 1, 0, 0, 0, 1, 2, "R6");
        step(0, 1, 1, 0, 1, 0, 0, "R6"); step(0, 1, 1, 0, 1, 0, 0, "R6");
        step(0, 1, 1, 0, 0, 0, 0, "R6"); step(0, 1, 1, 0, 0, 0, 0, "R6");
        step(1, 1, 0, 0, 0, 0, 0, "R6 equal");

        // R10: mixed pseudo-random traffic with mode switching
        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom_range(0, NE - 1), $urandom_range(0, 1),
                 ($urandom_range(0, 15) == 0), $urandom_range(0, 5), "R10 mix");
        end
        idle(3);
        chk(exp_q.size() == 0, "R2 drain", exp_q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule